// File: doc/BRIEF.md
# Flash End-of-Write Status Reporter

This block produces the word a host sees when it reads a flash bank while an internally timed program or erase runs. A start pulse, qualified by an operation type (program or erase) and the word being programmed, opens a busy window whose length is a parameter in clock cycles. While busy, each read strobe returns a status word instead of array contents: a polling bit that shows the complement of the programmed word's bit 7 (or a constant 0 for an erase), and a toggle bit that flips from one read to the next.

Once the busy window ends, a short settling window follows. In it the polling bit already shows true data while the other bits still carry the last status pattern. After that, reads return the stored array word unchanged. A start that arrives while busy is ignored, as the bank ignores further commands during an internal operation. A start during the settling window or when idle begins a new operation.

Top module: `flash_status_reporter`

## Requirements
- R1: A read strobe sampled on a clock edge produces `rd_valid_o` high for exactly the following cycle, with `rd_data_o` updated at that same edge; with no strobe `rd_valid_o` is low.
- R2: A start sampled while not busy makes `busy_o` high from the next cycle for exactly `BUSY_CYCLES` cycles.
- R3: A read during a busy program returns bit 7 equal to the complement of bit 7 of the programmed word.
- R4: A read during a busy erase returns bit 7 equal to 0.
- R5: During busy, bit 6 of the first read after a start is 0 and each further busy read returns the opposite bit 6 of the previous busy read; cycles without a read do not flip it.
- R6: During busy, all bits other than 7 and 6 read as 0 and the array word is not returned.
- R7: `done_o` is high for exactly one cycle, the cycle right after the last busy cycle.
- R8: For `SETTLE_CYCLES` cycles after busy, a read returns bit 7 as true data (array bit 7 after a program, 1 after an erase) and all other bits equal to the last word returned by a busy read of that operation, or 0 when no busy read happened.
- R9: When neither busy nor settling, a read returns the array word unchanged.
- R10: A start sampled while busy is ignored: the busy length, operation type and programmed word of the running operation stay as they were.
- R11: A start sampled during the settling window begins a new operation at once, with the toggle bit back at 0.
- R12: After reset `busy_o`, `done_o`, `rd_valid_o` and `rd_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a program or erase |
| op_erase_i | input | 1 | Operation type at start: 0 program, 1 erase |
| prog_word_i | input | 16 | Word being programmed, taken at start |
| rd_i | input | 1 | Read strobe |
| array_word_i | input | 16 | Stored array word at the read location |
| rd_data_o | output | 16 | Word returned for the last read |
| rd_valid_o | output | 1 | High in the cycle after a read strobe |
| busy_o | output | 1 | Internal operation in progress |
| done_o | output | 1 | One-cycle pulse when the operation completes |

## Verification
Programs are run with bit 7 of the word set and cleared, so an inverted polling bit is told apart from a copied one, and erases are run beside them to separate the constant-0 case. Busy windows are read on every cycle, on no cycle and on random cycles: the first shows strict alternation of the toggle bit, the second shows that the settling word falls back to zeros, and the third shows that only reads advance the toggle. A start injected mid-busy with the opposite type and word, and a start issued during settling, separate an ignored command from an accepted one, while random array words on every read distinguish true data from status in each window.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    parameter int unsigned WORD_W     = 16;
    parameter int unsigned POLL_BIT   = 7;
    parameter int unsigned TOGGLE_BIT = 6;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUSY   = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef struct packed {
        op_e   op;
        word_t word;
    } op_ctx_t;

    // Status word shown while the internal operation runs.
    function automatic word_t status_word(input op_e op, input logic prog_bit, input logic tog);
        word_t w;
        w             = '0;
        w[POLL_BIT]   = (op == OP_ERASE) ? 1'b0 : ~prog_bit;
        w[TOGGLE_BIT] = tog;
        return w;
    endfunction

    // Word shown during the settling window: true polling bit, stale remainder.
    function automatic word_t settle_word(input op_e op, input word_t last, input word_t arr);
        word_t w;
        w           = last;
        w[POLL_BIT] = (op == OP_ERASE) ? 1'b1 : arr[POLL_BIT];
        return w;
    endfunction

endpackage

// File: rtl/fsr_timer.sv
module fsr_timer
    import flash_status_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES   = 20,
    parameter int unsigned SETTLE_CYCLES = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    output phase_e phase_o,
    output logic   accept_o,
    output logic   done_o
);
    localparam int unsigned MAXC  = (BUSY_CYCLES > SETTLE_CYCLES) ? BUSY_CYCLES : SETTLE_CYCLES;
    localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] BUSY_LD   = CNT_W'(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    assign accept_o = start_i && (phase_q != PH_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                phase_q <= PH_BUSY;
                cnt_q   <= BUSY_LD;
            end else begin
                case (phase_q)
                    PH_BUSY: begin
                        if (cnt_q == ONE) begin
                            done_q <= 1'b1;
                            if (SETTLE_CYCLES == 0) begin
                                phase_q <= PH_IDLE;
                                cnt_q   <= '0;
                            end else begin
                                phase_q <= PH_SETTLE;
                                cnt_q   <= SETTLE_LD;
                            end
                        end else begin
                            cnt_q <= cnt_q - ONE;
                        end
                    end
                    PH_SETTLE: begin
                        if (cnt_q == ONE) begin
                            phase_q <= PH_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q - ONE;
                        end
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    assign phase_o = phase_q;
    assign done_o  = done_q;

endmodule

// File: rtl/fsr_context.sv
module fsr_context
    import flash_status_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept_i,
    input  logic    op_erase_i,
    input  word_t   prog_word_i,
    input  phase_e  phase_i,
    input  logic    rd_i,
    output op_ctx_t ctx_o,
    output logic    tog_o,
    output word_t   last_o
);
    op_ctx_t ctx_q;
    logic    tog_q;
    word_t   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '{op: OP_PROGRAM, word: '0};
            tog_q  <= 1'b0;
            last_q <= '0;
        end else if (accept_i) begin
            ctx_q.op   <= op_erase_i ? OP_ERASE : OP_PROGRAM;
            ctx_q.word <= prog_word_i;
            tog_q      <= 1'b0;
            last_q     <= '0;
        end else if (rd_i && (phase_i == PH_BUSY)) begin
            tog_q  <= ~tog_q;
            last_q <= status_word(ctx_q.op, ctx_q.word[POLL_BIT], tog_q);
        end
    end

    assign ctx_o  = ctx_q;
    assign tog_o  = tog_q;
    assign last_o = last_q;

endmodule

// File: rtl/fsr_readout.sv
module fsr_readout
    import flash_status_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_i,
    input  phase_e  phase_i,
    input  op_ctx_t ctx_i,
    input  logic    tog_i,
    input  word_t   last_i,
    input  word_t   array_word_i,
    output word_t   rd_data_o,
    output logic    rd_valid_o
);
    word_t next_word;
    word_t data_q;
    logic  valid_q;

    always_comb begin
        case (phase_i)
            PH_BUSY:   next_word = status_word(ctx_i.op, ctx_i.word[POLL_BIT], tog_i);
            PH_SETTLE: next_word = settle_word(ctx_i.op, last_i, array_word_i);
            default:   next_word = array_word_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_i;
            if (rd_i) begin
                data_q <= next_word;
            end
        end
    end

    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;

endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
    import flash_status_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES   = 20,
    parameter int unsigned SETTLE_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [WORD_W-1:0] prog_word_i,
    input  logic              rd_i,
    input  logic [WORD_W-1:0] array_word_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              done_o
);
    phase_e  phase;
    logic    accept;
    op_ctx_t ctx;
    logic    tog;
    word_t   last;

    fsr_timer #(
        .BUSY_CYCLES  (BUSY_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .phase_o (phase),
        .accept_o(accept),
        .done_o  (done_o)
    );

    fsr_context context_i (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .op_erase_i (op_erase_i),
        .prog_word_i(prog_word_i),
        .phase_i    (phase),
        .rd_i       (rd_i),
        .ctx_o      (ctx),
        .tog_o      (tog),
        .last_o     (last)
    );

    fsr_readout readout_i (
        .clk         (clk),
        .rst         (rst),
        .rd_i        (rd_i),
        .phase_i     (phase),
        .ctx_i       (ctx),
        .tog_i       (tog),
        .last_i      (last),
        .array_word_i(array_word_i),
        .rd_data_o   (rd_data_o),
        .rd_valid_o  (rd_valid_o)
    );

    assign busy_o = (phase == PH_BUSY);

endmodule

// File: rtl/flash_status_reporter_chk.sv
module flash_status_reporter_chk
    import flash_status_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              op_erase_i,
    input logic [WORD_W-1:0] prog_word_i,
    input logic              rd_i,
    input logic [WORD_W-1:0] array_word_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic              rd_valid_o,
    input logic              busy_o,
    input logic              done_o
);
    logic lat_erase;
    logic lat_w7;
    logic pend_busy;
    logic have_prev;
    logic prev_tog;
    word_t other_mask;

    always_comb begin
        other_mask             = '1;
        other_mask[POLL_BIT]   = 1'b0;
        other_mask[TOGGLE_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_erase <= 1'b0;
            lat_w7    <= 1'b0;
            pend_busy <= 1'b0;
            have_prev <= 1'b0;
            prev_tog  <= 1'b0;
        end else begin
            pend_busy <= rd_i && busy_o;
            if (start_i && !busy_o) begin
                lat_erase <= op_erase_i;
                lat_w7    <= prog_word_i[POLL_BIT];
                have_prev <= 1'b0;
            end else if (rd_valid_o && pend_busy) begin
                have_prev <= 1'b1;
                prev_tog  <= rd_data_o[TOGGLE_BIT];
            end
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_i) && !$past(rst)) |-> rd_valid_o) else $error("read latency"); // R1
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i)) else $error("busy without start"); // R2
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && pend_busy && !lat_erase) |-> (rd_data_o[POLL_BIT] == ~lat_w7)) else $error("program poll"); // R3
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && pend_busy && lat_erase) |-> !rd_data_o[POLL_BIT]) else $error("erase poll"); // R4
    AST_TOGGLE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && pend_busy && !have_prev) |-> !rd_data_o[TOGGLE_BIT]) else $error("toggle first"); // R5
    AST_TOGGLE_ALT: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && pend_busy && have_prev) |-> (rd_data_o[TOGGLE_BIT] != prev_tog)) else $error("toggle alternation"); // R5
    AST_BUSY_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && pend_busy) |-> ((rd_data_o & other_mask) == '0)) else $error("busy other bits"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))) else $error("done pulse"); // R7

endmodule

bind flash_status_reporter flash_status_reporter_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .op_erase_i  (op_erase_i),
    .prog_word_i (prog_word_i),
    .rd_i        (rd_i),
    .array_word_i(array_word_i),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/flash_status_reporter_tb_top.sv
module flash_status_reporter_tb_top;

    localparam int B = 20;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        op_erase_i;
    logic [15:0] prog_word_i;
    logic        rd_i;
    logic [15:0] array_word_i;
    logic [15:0] rd_data_o;
    logic        rd_valid_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_status_reporter #(.BUSY_CYCLES(B), .SETTLE_CYCLES(S)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_erase_i(op_erase_i),
        .prog_word_i(prog_word_i), .rd_i(rd_i), .array_word_i(array_word_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected busy status word (R3, R4, R5, R6)
    function automatic logic [15:0] exp_busy(input logic er, input logic [15:0] w, input logic tog);
        logic [15:0] e;
        e    = '0;
        e[7] = er ? 1'b0 : ~w[7];
        e[6] = tog;
        return e;
    endfunction

    // Expected settling word (R8)
    function automatic logic [15:0] exp_settle(input logic er, input logic [15:0] last, input logic [15:0] arr);
        logic [15:0] e;
        e    = last;
        e[7] = er ? 1'b1 : arr[7];
        return e;
    endfunction

    // mode: 0 random reads, 1 read every cycle, 2 no reads in busy then always read
    task automatic run_op(input logic er, input logic [15:0] w, input int stop_k,
                          input int mode, input bit inject);
        logic        tog = 1'b0;
        logic [15:0] last = '0;
        @(negedge clk);
        start_i = 1'b1; op_erase_i = er; prog_word_i = w; rd_i = 1'b0;
        array_word_i = 16'($urandom);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= stop_k; k++) begin
            logic        rd;
            logic [15:0] arr;
            logic [15:0] e;
            if (mode == 1) rd = 1'b1;
            else if (mode == 2) rd = (k > B);
            else rd = 1'($urandom % 2);
            arr = 16'($urandom);
            rd_i = rd; array_word_i = arr;
            if (inject && k == 3) begin
                start_i = 1'b1; op_erase_i = ~er; prog_word_i = ~w;
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0; rd_i = 1'b0;
            chk("R1 rd_valid", {15'd0, rd_valid_o}, {15'd0, rd});
            if (rd) begin
                if (k <= B) begin
                    e = exp_busy(er, w, tog);
                    tog = ~tog;
                    last = e;
                    chk(er ? "R4/R5/R6/R10 busy read" : "R3/R5/R6/R10 busy read", rd_data_o, e);
                end else if (k <= B + S) begin
                    chk("R8 settle read", rd_data_o, exp_settle(er, last, arr));
                end else begin
                    chk("R9 idle read", rd_data_o, arr);
                end
            end
            chk(inject ? "R2/R10 busy_o" : "R2 busy_o", {15'd0, busy_o}, {15'd0, (k < B)});
            chk("R7 done_o", {15'd0, done_o}, {15'd0, (k == B)});
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; op_erase_i = 1'b0; prog_word_i = '0;
        rd_i = 1'b0; array_word_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12 busy_o", {15'd0, busy_o}, 16'd0);
        chk("R12 done_o", {15'd0, done_o}, 16'd0);
        chk("R12 rd_valid_o", {15'd0, rd_valid_o}, 16'd0);
        chk("R12 rd_data_o", rd_data_o, 16'd0);
        // R9 idle read before any operation
        rd_i = 1'b1; array_word_i = 16'hA5C3;
        @(posedge clk); @(negedge clk);
        rd_i = 1'b0;
        chk("R9 idle read", rd_data_o, 16'hA5C3);
        // Directed programs, bit 7 set and clear, every-cycle reads (R3, R5)
        run_op(1'b0, 16'h0080, B + S + 2, 1, 1'b0);
        run_op(1'b0, 16'hFF7F, B + S + 2, 1, 1'b0);
        // Erase with every-cycle reads (R4)
        run_op(1'b1, 16'h1234, B + S + 2, 1, 1'b0);
        // No busy reads: settle shows zero remainder (R8)
        run_op(1'b1, 16'h0000, B + S + 2, 2, 1'b0);
        run_op(1'b0, 16'h00FF, B + S + 2, 2, 1'b0);
        // Start ignored while busy (R10)
        run_op(1'b0, 16'h0080, B + S + 2, 0, 1'b1);
        run_op(1'b1, 16'h5555, B + S + 2, 1, 1'b1);
        // Restart during settling window (R11)
        run_op(1'b0, 16'h0000, B + 1, 1, 1'b0);
        run_op(1'b1, 16'hFFFF, B + S + 2, 1, 1'b0);
        // Constrained random operations
        for (int n = 0; n < 8; n++) begin
            run_op(1'($urandom % 2), 16'($urandom), B + S + 1 + int'($urandom % 4),
                   int'($urandom % 3), 1'($urandom % 2));
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule